// File: doc/BRIEF.md
# Peripheral Clock Channel Configuration Bank

This block keeps the configuration that steers a chip's clock tree. It holds a small set of clock generators, a set of peripheral clock channels, and the CPU and bus prescaler codes. Each generator has an enable and a source select. Each peripheral channel has an enable, a select that names the generator feeding it, and a write-lock bit. The multiplexers and dividers that act on these settings sit outside the block. They read its output ports directly.

Software reaches the registers through a single write port and a combinational read port. Both ports share one address format. The two top address bits pick a space: 0 for generators, 1 for channels, 2 for prescalers, and 3 is unused. The low `IDX_W` bits give the index within that space.

The block takes two synchronous active-low reset inputs. A power reset clears everything. A user reset restores the defaults but leaves locked channels alone, so a peripheral that must keep running across a soft reset can do so. Generator 0 feeds the main system clock. It always comes out of reset enabled and running from the high-speed source.

Top module: `clkchan_cfg`

## Requirements
- R1: After power reset, generator 0 is enabled with source code `HS_SRC`, and every other generator is disabled with source 0. Power reset takes priority over user reset and over writes.
- R2: After power reset, every channel is disabled, selects generator 0 and is unlocked.
- R3: After either reset, both prescaler codes are 0, which means divide by one (code k divides by 2^k).
- R4: After user reset, all generators return to their power-reset values.
- R5: After user reset, each unlocked channel returns to disabled, generator 0 and unlocked. Each locked channel keeps its enable, select and lock bit.
- R6: A write updates the addressed register at the next clock edge, and the output ports show the new value. Generator data: bit 0 is the enable and bits [SRC_W:1] are the source. Channel data: bit 0 is the enable, bits [GSEL_W:1] are the generator select, and bit DATA_W-1 is the lock. Prescaler index 0 is the CPU code and index 1 is the bus code, held in bits [DIV_W-1:0].
- R7: A write to a channel whose lock bit is set has no effect, and that includes an attempt to clear the lock.
- R8: Only power reset clears a lock bit. After it, the channel accepts writes again.
- R9: A read of an in-range address returns the current register value in the same field layout as writes, with the lock bit included.
- R10: A write to an out-of-range address changes nothing. Out-of-range means space 3, a generator index at or above `NUM_GEN`, a channel index at or above `NUM_CH`, or a prescaler index above 1. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, synchronous, active low |
| usr_rst_n | input | 1 | User reset, synchronous, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address {space, index} |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address {space, index} |
| rd_data | output | DATA_W | Read data (combinational) |
| gen_en | output | NUM_GEN | Per-generator enable |
| gen_src | output | NUM_GEN*SRC_W | Per-generator source select, generator g at [g*SRC_W +: SRC_W] |
| ch_en | output | NUM_CH | Per-channel enable |
| ch_gen | output | NUM_CH*GSEL_W | Per-channel generator select |
| ch_lock | output | NUM_CH | Per-channel write-lock |
| cpu_div | output | DIV_W | CPU prescaler code |
| bus_div | output | DIV_W | Bus prescaler code |

## Verification
The bench builds the block with its defaults: four generators, six channels, a 3-bit index and 3-bit source and prescaler fields. With these values, generator indices 4 to 7, channel indices 6 and 7, and prescaler indices 2 to 7 are legal addresses that map to no register, so the out-of-range paths are easy to hit. With only six channels, random writes set lock bits often. The random user and power resets that follow then meet a mix of locked and unlocked channels, and the bench checks both the preservation and the clearing of those channels.

// File: rtl/clkchan_pkg.sv
package clkchan_pkg;

    // Address space decoded from the two top address bits
    typedef enum logic [1:0] {
        SPACE_GEN  = 2'd0,
        SPACE_CHAN = 2'd1,
        SPACE_DIV  = 2'd2,
        SPACE_VOID = 2'd3
    } space_e;

    // Prescaler slot indices inside SPACE_DIV
    localparam int unsigned DIV_CPU_IDX = 0;
    localparam int unsigned DIV_BUS_IDX = 1;

endpackage

// File: rtl/clkchan_gen_bank.sv
module clkchan_gen_bank #(
    parameter int unsigned NUM_GEN = 4,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned HS_SRC  = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     usr_rst_n,
    input  logic                     wr_sel,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_on,
    input  logic [SRC_W-1:0]         wr_src,
    output logic [NUM_GEN-1:0]       gen_en,
    output logic [NUM_GEN*SRC_W-1:0] gen_src
);

    typedef struct packed {
        logic [NUM_GEN-1:0]            en;
        logic [NUM_GEN-1:0][SRC_W-1:0] src;
    } bank_t;

    bank_t bank_d, bank_q;

    // Default: only generator 0 runs, from the high-speed source
    function automatic bank_t bank_default();
        bank_t b;
        b        = '0;
        b.en[0]  = 1'b1;
        b.src[0] = SRC_W'(HS_SRC);
        return b;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (!por_n || !usr_rst_n) begin
            bank_d = bank_default();
        end else if (wr_sel) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (wr_idx == IDX_W'(g)) begin
                    bank_d.en[g]  = wr_on;
                    bank_d.src[g] = wr_src;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign gen_en  = bank_q.en;
    assign gen_src = bank_q.src;

endmodule

// File: rtl/clkchan_presc.sv
module clkchan_presc
    import clkchan_pkg::*;
#(
    parameter int unsigned DIV_W = 3,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             usr_rst_n,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DIV_W-1:0] wr_val,
    output logic [DIV_W-1:0] cpu_div,
    output logic [DIV_W-1:0] bus_div
);

    typedef struct packed {
        logic [DIV_W-1:0] cpu;
        logic [DIV_W-1:0] bus;
    } presc_t;

    presc_t presc_d, presc_q;

    always_comb begin
        presc_d = presc_q;
        if (!por_n || !usr_rst_n) begin
            presc_d = '0;                      // code 0: undivided
        end else if (wr_sel) begin
            if (wr_idx == IDX_W'(DIV_CPU_IDX)) presc_d.cpu = wr_val;
            if (wr_idx == IDX_W'(DIV_BUS_IDX)) presc_d.bus = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        presc_q <= presc_d;
    end

    assign cpu_div = presc_q.cpu;
    assign bus_div = presc_q.bus;

endmodule

// File: rtl/clkchan_slot.sv
module clkchan_slot #(
    parameter int unsigned GSEL_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              usr_rst_n,
    input  logic              wr_hit,
    input  logic              wr_on,
    input  logic [GSEL_W-1:0] wr_gsel,
    input  logic              wr_lock,
    output logic              en,
    output logic [GSEL_W-1:0] gsel,
    output logic              lock
);

    typedef struct packed {
        logic              en;
        logic [GSEL_W-1:0] gsel;
        logic              lock;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (!por_n) begin
            slot_d = '0;
        end else if (!usr_rst_n) begin
            // a locked slot rides through user reset untouched
            if (!slot_q.lock) slot_d = '0;
        end else if (wr_hit && !slot_q.lock) begin
            slot_d.en   = wr_on;
            slot_d.gsel = wr_gsel;
            slot_d.lock = wr_lock;
        end
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign en   = slot_q.en;
    assign gsel = slot_q.gsel;
    assign lock = slot_q.lock;

endmodule

// File: rtl/clkchan_cfg.sv
module clkchan_cfg
    import clkchan_pkg::*;
#(
    parameter int unsigned NUM_GEN = 4,
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned HS_SRC  = 6,
    parameter int unsigned DIV_W   = 3,
    localparam int unsigned GSEL_W    = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
    localparam int unsigned ADDR_W    = IDX_W + 2,
    localparam int unsigned GEN_BITS  = SRC_W + 1,
    localparam int unsigned CHAN_BITS = GSEL_W + 2,
    localparam int unsigned DATA_W    = (GEN_BITS > CHAN_BITS)
                                        ? ((GEN_BITS > DIV_W) ? GEN_BITS : DIV_W)
                                        : ((CHAN_BITS > DIV_W) ? CHAN_BITS : DIV_W)
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      usr_rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_GEN-1:0]        gen_en,
    output logic [NUM_GEN*SRC_W-1:0]  gen_src,
    output logic [NUM_CH-1:0]         ch_en,
    output logic [NUM_CH*GSEL_W-1:0]  ch_gen,
    output logic [NUM_CH-1:0]         ch_lock,
    output logic [DIV_W-1:0]          cpu_div,
    output logic [DIV_W-1:0]          bus_div
);

    localparam int unsigned LOCK_BIT = DATA_W - 1;

    space_e           wr_space, rd_space;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    assign wr_space = space_e'(wr_addr[ADDR_W-1 -: 2]);
    assign wr_idx   = wr_addr[IDX_W-1:0];
    assign rd_space = space_e'(rd_addr[ADDR_W-1 -: 2]);
    assign rd_idx   = rd_addr[IDX_W-1:0];

    clkchan_gen_bank #(
        .NUM_GEN (NUM_GEN),
        .SRC_W   (SRC_W),
        .HS_SRC  (HS_SRC),
        .IDX_W   (IDX_W)
    ) u_gens (
        .clk       (clk),
        .por_n     (por_n),
        .usr_rst_n (usr_rst_n),
        .wr_sel    (wr_en && (wr_space == SPACE_GEN)),
        .wr_idx    (wr_idx),
        .wr_on     (wr_data[0]),
        .wr_src    (wr_data[SRC_W:1]),
        .gen_en    (gen_en),
        .gen_src   (gen_src)
    );

    clkchan_presc #(
        .DIV_W (DIV_W),
        .IDX_W (IDX_W)
    ) u_presc (
        .clk       (clk),
        .por_n     (por_n),
        .usr_rst_n (usr_rst_n),
        .wr_sel    (wr_en && (wr_space == SPACE_DIV)),
        .wr_idx    (wr_idx),
        .wr_val    (wr_data[DIV_W-1:0]),
        .cpu_div   (cpu_div),
        .bus_div   (bus_div)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        clkchan_slot #(
            .GSEL_W (GSEL_W)
        ) u_slot (
            .clk       (clk),
            .por_n     (por_n),
            .usr_rst_n (usr_rst_n),
            .wr_hit    (wr_en && (wr_space == SPACE_CHAN) && (wr_idx == IDX_W'(c))),
            .wr_on     (wr_data[0]),
            .wr_gsel   (wr_data[GSEL_W:1]),
            .wr_lock   (wr_data[LOCK_BIT]),
            .en        (ch_en[c]),
            .gsel      (ch_gen[c*GSEL_W +: GSEL_W]),
            .lock      (ch_lock[c])
        );
    end

    // Read mux: unmapped addresses fall through to zero
    always_comb begin
        rd_data = '0;
        unique case (rd_space)
            SPACE_GEN: begin
                for (int g = 0; g < NUM_GEN; g++) begin
                    if (rd_idx == IDX_W'(g)) begin
                        rd_data[0]       = gen_en[g];
                        rd_data[SRC_W:1] = gen_src[g*SRC_W +: SRC_W];
                    end
                end
            end
            SPACE_CHAN: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rd_idx == IDX_W'(c)) begin
                        rd_data[0]        = ch_en[c];
                        rd_data[GSEL_W:1] = ch_gen[c*GSEL_W +: GSEL_W];
                        rd_data[LOCK_BIT] = ch_lock[c];
                    end
                end
            end
            SPACE_DIV: begin
                if (rd_idx == IDX_W'(DIV_CPU_IDX)) rd_data[DIV_W-1:0] = cpu_div;
                if (rd_idx == IDX_W'(DIV_BUS_IDX)) rd_data[DIV_W-1:0] = bus_div;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/clkchan_cfg_chk.sv
module clkchan_cfg_chk #(
    parameter int unsigned NUM_GEN = 4,
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned HS_SRC  = 6,
    parameter int unsigned DIV_W   = 3,
    parameter int unsigned GSEL_W  = 2,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 4
) (
    input logic                     clk,
    input logic                     por_n,
    input logic                     usr_rst_n,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic [NUM_GEN-1:0]       gen_en,
    input logic [NUM_GEN*SRC_W-1:0] gen_src,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH*GSEL_W-1:0] ch_gen,
    input logic [NUM_CH-1:0]        ch_lock,
    input logic [DIV_W-1:0]         cpu_div,
    input logic [DIV_W-1:0]         bus_div
);

    logic [1:0] rd_sp;
    int unsigned rd_ix;
    logic rd_void;

    assign rd_sp = rd_addr[ADDR_W-1 -: 2];
    assign rd_ix = int'(rd_addr[IDX_W-1:0]);
    assign rd_void = (rd_sp == 2'd3)
                   || ((rd_sp == 2'd0) && (rd_ix >= NUM_GEN))
                   || ((rd_sp == 2'd1) && (rd_ix >= NUM_CH))
                   || ((rd_sp == 2'd2) && (rd_ix >= 2));

    // R1
    gen0_main_after_por_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(por_n) |-> (gen_en == NUM_GEN'(1)) && (gen_src[SRC_W-1:0] == SRC_W'(HS_SRC)));

    // R2
    chan_clear_after_por_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(por_n) |-> (ch_en == '0) && (ch_lock == '0) && (ch_gen == '0));

    // R3
    presc_undivided_after_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(por_n) || !$past(usr_rst_n)) |-> (cpu_div == '0) && (bus_div == '0));

    // R4
    gens_default_after_usr_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && !$past(usr_rst_n)) |-> (gen_en == NUM_GEN'(1)));

    // R5
    usr_reset_keeps_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && !$past(usr_rst_n)) |->
            (ch_lock == $past(ch_lock)) && ((ch_en & ~ch_lock) == '0));

    // R10
    void_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_void |-> (rd_data == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
        // R7
        locked_slot_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
            ($past(por_n) && $past(ch_lock[c])) |->
                ch_lock[c] && $stable(ch_en[c]) && $stable(ch_gen[c*GSEL_W +: GSEL_W]));
    end

endmodule

bind clkchan_cfg clkchan_cfg_chk #(
    .NUM_GEN (NUM_GEN),
    .NUM_CH  (NUM_CH),
    .IDX_W   (IDX_W),
    .SRC_W   (SRC_W),
    .HS_SRC  (HS_SRC),
    .DIV_W   (DIV_W),
    .GSEL_W  (GSEL_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .usr_rst_n (usr_rst_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .gen_en    (gen_en),
    .gen_src   (gen_src),
    .ch_en     (ch_en),
    .ch_gen    (ch_gen),
    .ch_lock   (ch_lock),
    .cpu_div   (cpu_div),
    .bus_div   (bus_div)
);

// File: tb/clkchan_cfg_test.sv
`timescale 1ns/100ps
module clkchan_cfg_test;

    localparam int unsigned NUM_GEN  = 4;
    localparam int unsigned NUM_CH   = 6;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned SRC_W    = 3;
    localparam int unsigned HS_SRC   = 6;
    localparam int unsigned DIV_W    = 3;
    localparam int unsigned GSEL_W   = 2;
    localparam int unsigned ADDR_W   = IDX_W + 2;
    localparam int unsigned DATA_W   = 4;
    localparam int unsigned LOCK_BIT = DATA_W - 1;

    logic                     clk = 1'b0;
    logic                     por_n = 1'b0;
    logic                     usr_rst_n = 1'b1;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic [ADDR_W-1:0]        rd_addr = '0;
    logic [DATA_W-1:0]        rd_data;
    logic [NUM_GEN-1:0]       gen_en;
    logic [NUM_GEN*SRC_W-1:0] gen_src;
    logic [NUM_CH-1:0]        ch_en;
    logic [NUM_CH*GSEL_W-1:0] ch_gen;
    logic [NUM_CH-1:0]        ch_lock;
    logic [DIV_W-1:0]         cpu_div;
    logic [DIV_W-1:0]         bus_div;

    always #2 clk = ~clk;

    clkchan_cfg uut (
        .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .gen_en(gen_en), .gen_src(gen_src),
        .ch_en(ch_en), .ch_gen(ch_gen), .ch_lock(ch_lock),
        .cpu_div(cpu_div), .bus_div(bus_div)
    );

    // Reference model
    logic             m_gen_en  [NUM_GEN];
    logic [SRC_W-1:0] m_gen_src [NUM_GEN];
    logic             m_ch_en   [NUM_CH];
    logic [GSEL_W-1:0] m_ch_gsel[NUM_CH];
    logic             m_ch_lock [NUM_CH];
    logic [DIV_W-1:0] m_cpu, m_bus;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    bit          done    = 1'b0;

    function automatic void model_gens_default();
        for (int g = 0; g < NUM_GEN; g++) begin
            m_gen_en[g]  = (g == 0);
            m_gen_src[g] = (g == 0) ? SRC_W'(HS_SRC) : '0;
        end
        m_cpu = '0;
        m_bus = '0;
    endfunction

    function automatic void model_por();
        model_gens_default();
        for (int c = 0; c < NUM_CH; c++) begin
            m_ch_en[c] = 1'b0; m_ch_gsel[c] = '0; m_ch_lock[c] = 1'b0;
        end
    endfunction

    function automatic void model_usr();
        model_gens_default();
        for (int c = 0; c < NUM_CH; c++) begin
            if (!m_ch_lock[c]) begin
                m_ch_en[c] = 1'b0; m_ch_gsel[c] = '0;
            end
        end
    endfunction

    function automatic void model_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        int unsigned sp = int'(a[ADDR_W-1 -: 2]);
        int unsigned ix = int'(a[IDX_W-1:0]);
        if (sp == 0 && ix < NUM_GEN) begin
            m_gen_en[ix] = d[0]; m_gen_src[ix] = d[SRC_W:1];
        end else if (sp == 1 && ix < NUM_CH) begin
            if (!m_ch_lock[ix]) begin
                m_ch_en[ix] = d[0]; m_ch_gsel[ix] = d[GSEL_W:1]; m_ch_lock[ix] = d[LOCK_BIT];
            end
        end else if (sp == 2 && ix == 0) begin
            m_cpu = d[DIV_W-1:0];
        end else if (sp == 2 && ix == 1) begin
            m_bus = d[DIV_W-1:0];
        end
    endfunction

    function automatic bit addr_valid(logic [ADDR_W-1:0] a);
        int unsigned sp = int'(a[ADDR_W-1 -: 2]);
        int unsigned ix = int'(a[IDX_W-1:0]);
        return (sp == 0 && ix < NUM_GEN) || (sp == 1 && ix < NUM_CH) || (sp == 2 && ix < 2);
    endfunction

    function automatic logic [DATA_W-1:0] exp_read(logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] r = '0;
        int unsigned sp = int'(a[ADDR_W-1 -: 2]);
        int unsigned ix = int'(a[IDX_W-1:0]);
        if (sp == 0 && ix < NUM_GEN) begin
            r[0] = m_gen_en[ix]; r[SRC_W:1] = m_gen_src[ix];
        end else if (sp == 1 && ix < NUM_CH) begin
            r[0] = m_ch_en[ix]; r[GSEL_W:1] = m_ch_gsel[ix]; r[LOCK_BIT] = m_ch_lock[ix];
        end else if (sp == 2 && ix == 0) begin
            r[DIV_W-1:0] = m_cpu;
        end else if (sp == 2 && ix == 1) begin
            r[DIV_W-1:0] = m_bus;
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output port and every read address against the model
    task automatic check_state(string req);
        for (int g = 0; g < NUM_GEN; g++) begin
            chk(req, $sformatf("gen%0d en", g), 32'(gen_en[g]), 32'(m_gen_en[g]));
            chk(req, $sformatf("gen%0d src", g), 32'(gen_src[g*SRC_W +: SRC_W]), 32'(m_gen_src[g]));
        end
        for (int c = 0; c < NUM_CH; c++) begin
            chk(req, $sformatf("ch%0d en", c), 32'(ch_en[c]), 32'(m_ch_en[c]));
            chk(req, $sformatf("ch%0d gsel", c), 32'(ch_gen[c*GSEL_W +: GSEL_W]), 32'(m_ch_gsel[c]));
            chk(req, $sformatf("ch%0d lock", c), 32'(ch_lock[c]), 32'(m_ch_lock[c]));
        end
        chk(req, "cpu_div", 32'(cpu_div), 32'(m_cpu));
        chk(req, "bus_div", 32'(bus_div), 32'(m_bus));
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            @(negedge clk);
            rd_addr = ADDR_W'(a);
            #0.5;
            if (addr_valid(ADDR_W'(a)))
                chk("R9", $sformatf("read %0h", a), 32'(rd_data), 32'(exp_read(ADDR_W'(a))));
            else
                chk("R10", $sformatf("read %0h", a), 32'(rd_data), 32'(0));
        end
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic apply_por();
        @(negedge clk);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        model_por();
    endtask

    task automatic apply_usr();
        @(negedge clk);
        usr_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        usr_rst_n = 1'b1;
        model_usr();
    endtask

    function automatic logic [ADDR_W-1:0] mk(int unsigned sp, int unsigned ix);
        return {2'(sp), IDX_W'(ix)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h00C1_0C4E));
        model_por();
        apply_por();

        // R1 R2 R3: power reset state
        chk("R1", "gen_en", 32'(gen_en), 32'(1));
        chk("R1", "gen0 src", 32'(gen_src[SRC_W-1:0]), 32'(HS_SRC));
        chk("R2", "ch_en", 32'(ch_en), 32'(0));
        chk("R2", "ch_lock", 32'(ch_lock), 32'(0));
        chk("R3", "cpu_div", 32'(cpu_div), 32'(0));
        check_state("R1");

        // R6: writes to each space
        do_write(mk(0, 1), 4'b0101);              // gen1 on, src 2
        chk("R6", "gen1 en", 32'(gen_en[1]), 32'(1));
        chk("R6", "gen1 src", 32'(gen_src[SRC_W +: SRC_W]), 32'(2));
        do_write(mk(2, 0), 4'd3);
        do_write(mk(2, 1), 4'd5);
        chk("R6", "cpu_div", 32'(cpu_div), 32'(3));
        chk("R6", "bus_div", 32'(bus_div), 32'(5));

        // R7: lock channel 2, then try to change it
        do_write(mk(1, 2), 4'b1111);
        do_write(mk(1, 3), 4'b0011);
        do_write(mk(1, 2), 4'b0000);
        chk("R7", "ch2 en", 32'(ch_en[2]), 32'(1));
        chk("R7", "ch2 lock", 32'(ch_lock[2]), 32'(1));
        chk("R7", "ch2 gsel", 32'(ch_gen[2*GSEL_W +: GSEL_W]), 32'(3));
        check_state("R7");

        // R5 R4 R3: user reset keeps the locked channel only
        apply_usr();
        chk("R5", "ch2 en", 32'(ch_en[2]), 32'(1));
        chk("R5", "ch3 en", 32'(ch_en[3]), 32'(0));
        chk("R4", "gen_en", 32'(gen_en), 32'(1));
        chk("R3", "bus_div", 32'(bus_div), 32'(0));
        check_state("R5");

        // R10: out-of-range writes
        do_write(mk(3, 0), 4'hF);
        do_write(mk(1, 6), 4'hB);
        do_write(mk(0, 5), 4'h7);
        do_write(mk(2, 4), 4'h6);
        check_state("R10");

        // R8: power reset clears the lock, channel writable again
        apply_por();
        chk("R8", "ch_lock", 32'(ch_lock), 32'(0));
        do_write(mk(1, 2), 4'b0100);
        chk("R8", "ch2 gsel", 32'(ch_gen[2*GSEL_W +: GSEL_W]), 32'(2));
        check_state("R8");

        // Random mix
        for (int i = 0; i < 250; i++) begin
            int unsigned r = $urandom % 40;
            if (r == 0) begin
                apply_usr();
                check_state("R5");
            end else if (r == 1) begin
                apply_por();
                check_state("R2");
            end else begin
                do_write(ADDR_W'($urandom), DATA_W'($urandom));
                check_state("R6");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule